// File: doc/BRIEF.md
# Serial Non-Restoring Divider

This block divides an unsigned 32-bit dividend by an unsigned 32-bit divisor. It produces one quotient bit per clock, so a division takes 32 iteration cycles. The recurrence is non-restoring: each step either adds or subtracts the divisor, according to the sign of the partial remainder. The final remainder is returned raw, without a correction step, so it may be negative (its bit 31 set) where a restoring divider would have added the divisor back. The quotient is the correct unsigned quotient whenever the divisor is non-zero and no wider than 31 bits.

A mode input selects plain integer division or 16.16 fixed-point division. In fixed-point mode the dividend is treated as if it were scaled up by 2^16, so two 16.16 operands give a 16.16 quotient. The block takes a single-cycle start pulse and raises busy while it iterates. It then pulses done for one cycle, with quotient and remainder valid, and holds both results until the next accepted start. A zero divisor gets no special treatment: the recurrence runs unchanged and its output is returned.

Top module: `serial_divider`

## Requirements
- R1: While rst_ni is low and after it is released, busy_o and done_o are 0 and quotient_o and remainder_o are 0.
- R2: A start_i sampled high at a clock edge while busy_o is 0 is accepted. busy_o is 1 from that edge through the following 32 edges, and 0 after the 32nd.
- R3: done_o is 1 for exactly one cycle, the cycle after the 32nd iteration edge, and is 0 at all other times. It is never 1 together with busy_o.
- R4: With mode_i = 0 (integer), the working quotient starts as the dividend and the partial remainder starts as 0.
- R5: With mode_i = 1 (16.16), the partial remainder starts as dividend >> 16 and the working quotient starts as dividend << 16. For example, 0x00030000 / 0x00020000 gives quotient 0x00018000.
- R6: Each step does the following, in order:
  - It shifts the remainder left by one and moves the quotient MSB into the remainder LSB.
  - It adds the divisor if the remainder's bit 31 was 1 before the step, and subtracts the divisor otherwise.
  - It shifts the quotient left by one and inserts the inverse of the new remainder's bit 31 as the quotient LSB.
  - After the last step, the remainder is output uncorrected.
- R7: start_i is ignored while busy_o is 1. The running division's results and its done timing are unchanged.
- R8: mode_i, dividend_i and divisor_i are captured when start is accepted. Changing them while busy_o is 1 has no effect on the result.
- R9: A zero divisor is not trapped. In integer mode with a dividend below 2^31, the quotient is 0xFFFFFFFF and the remainder equals the dividend.
- R10: After done_o, quotient_o and remainder_o hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken only when idle |
| mode_i | input | 1 | 0 = integer division, 1 = 16.16 fixed-point |
| dividend_i | input | 32 | Unsigned dividend |
| divisor_i | input | 32 | Unsigned divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| quotient_o | output | 32 | Quotient |
| remainder_o | output | 32 | Raw, uncorrected remainder |

## Verification
- **Edge numbering.** The edge that accepts start is edge 0. busy_o is high from edge 0 and still high after edge 31. After edge 32, busy_o is low, done_o is high, and both results are final. After edge 33, done_o is low again.
- **Sampling.** The bench drives start on a falling edge. It then samples every output on the falling edge that follows each of these rising edges, so each check falls exactly in the cycle when the value is due.
- **Stability checks.** For the hold and ignored-start cases, the bench compares results several cycles after done_o against the values seen in the done cycle.

// File: rtl/serial_divider_pkg.sv
package serial_divider_pkg;
  typedef enum logic {
    MODE_INT = 1'b0,
    MODE_FIX = 1'b1
  } div_mode_e;
endpackage

// File: rtl/serial_divider_step.sv
// One non-restoring iteration, purely combinational.
module serial_divider_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W-1:0] shifted;

  always_comb begin
    shifted = {rem_i[W-2:0], quo_i[W-1]};
    // sign of the remainder before the step picks add or subtract
    if (rem_i[W-1]) rem_o = shifted + den_i;
    else            rem_o = shifted - den_i;
    quo_o = {quo_i[W-2:0], ~rem_o[W-1]};
  end
endmodule

// File: rtl/serial_divider_ctrl.sv
module serial_divider_ctrl #(
  parameter int ITER = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic accept_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = (ITER > 1) ? $clog2(ITER) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;
  logic             last;

  assign accept_o = start_i & ~busy_q;
  assign last     = (cnt_q == CNT_W'(ITER - 1));
  assign step_o   = busy_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= busy_q & last;
      if (accept_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (last) busy_q <= 1'b0;
      end
    end
  end

  a_r3_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r3_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  a_r2_busy_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> busy_q);
  a_r3_done_at_busy_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q);
  a_r7_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !last) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/serial_divider.sv
module serial_divider
  import serial_divider_pkg::*;
#(
  parameter int W    = 32,
  parameter int FRAC = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         mode_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o
);
  localparam int ITER = W;

  logic         accept, step;
  logic [W-1:0] rem_q, quo_q, den_q;
  logic [W-1:0] rem_nxt, quo_nxt;
  logic [W-1:0] rem_init, quo_init;
  div_mode_e    mode;

  assign mode = div_mode_e'(mode_i);

  serial_divider_ctrl #(.ITER(ITER)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .step_o   (step),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  serial_divider_step #(.W(W)) u_step (
    .rem_i (rem_q),
    .quo_i (quo_q),
    .den_i (den_q),
    .rem_o (rem_nxt),
    .quo_o (quo_nxt)
  );

  always_comb begin
    if (mode == MODE_FIX) begin
      rem_init = dividend_i >> FRAC;
      quo_init = dividend_i << FRAC;
    end else begin
      rem_init = '0;
      quo_init = dividend_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
    end else if (accept) begin
      rem_q <= rem_init;
      quo_q <= quo_init;
      den_q <= divisor_i;
    end else if (step) begin
      rem_q <= rem_nxt;
      quo_q <= quo_nxt;
    end
  end

  assign quotient_o  = quo_q;
  assign remainder_o = rem_q;

  a_r10_hold_quotient: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(quotient_o));
  a_r10_hold_remainder: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(remainder_o));
  a_r8_divisor_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$rose(busy_o)) |-> $stable(den_q));
  a_r4_int_preload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !mode_i) |=> (remainder_o == '0));
endmodule

// File: tb/serial_divider_bench.sv
`timescale 1ns/1ps
module serial_divider_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [31:0] dvd = '0;
  logic [31:0] dvs = '0;
  logic        busy, done;
  logic [31:0] quo, rem;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  serial_divider u_serial_divider (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .dividend_i(dvd), .divisor_i(dvs), .busy_o(busy), .done_o(done),
    .quotient_o(quo), .remainder_o(rem)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual cycles=%0d expected < 100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // reference recurrence from R4/R5/R6
  function automatic logic [63:0] model(input logic m, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] q, r, s;
    if (m) begin r = a >> 16; q = a << 16; end
    else   begin r = '0;      q = a;       end
    for (int i = 0; i < 32; i++) begin
      s = {r[30:0], q[31]};
      s = r[31] ? s + b : s - b;
      r = s;
      q = {q[30:0], ~r[31]};
    end
    return {q, r};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // start at negedge, then walk the 32 iteration edges; returns at negedge after edge 32
  task automatic run(input logic m, input logic [31:0] a, input logic [31:0] b,
                     input bit disturb, input bit restart);
    int busy_bad = 0;
    start = 1'b1; mode = m; dvd = a; dvs = b;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    chk("R2 busy after accept", {31'b0, busy}, 32'd1);
    for (int i = 1; i < 32; i++) begin
      if (disturb) begin mode = ~m; dvd = ~a; dvs = b + 32'd3; end
      if (restart && i == 10) begin start = 1'b1; dvd = 32'd5; dvs = 32'd1; end
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      if (busy !== 1'b1 || done !== 1'b0) busy_bad++;
    end
    chk("R2 busy held 32 cycles", busy_bad, 0);
    @(posedge clk); @(negedge clk);
    chk("R2 busy low after 32", {31'b0, busy}, 32'd0);
    chk("R3 done pulse", {31'b0, done}, 32'd1);
  endtask

  localparam logic [64:0] VEC [8] = '{
    {1'b0, 32'd100,        32'd7},
    {1'b0, 32'hFFFF_FFFF,  32'd3},
    {1'b0, 32'd6,          32'd9},
    {1'b0, 32'h8000_0001,  32'h7FFF_FFFF},
    {1'b1, 32'h0003_0000,  32'h0002_0000},
    {1'b1, 32'h0001_0000,  32'h0000_0003},
    {1'b1, 32'h00FF_8000,  32'h0000_4000},
    {1'b0, 32'h1234_5678,  32'h0000_0100}
  };

  initial begin
    logic [63:0] e;
    logic [31:0] hq, hr;
    @(negedge clk);
    chk("R1 busy in reset", {31'b0, busy}, 32'd0);
    chk("R1 quotient in reset", quo, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", {31'b0, done}, 32'd0);
    chk("R1 remainder after reset", rem, 32'd0);

    foreach (VEC[k]) begin
      e = model(VEC[k][64], VEC[k][63:32], VEC[k][31:0]);
      run(VEC[k][64], VEC[k][63:32], VEC[k][31:0], 1'b0, 1'b0);
      chk(VEC[k][64] ? "R5 quotient" : "R4 quotient", quo, e[63:32]);
      chk("R6 raw remainder", rem, e[31:0]);
      @(negedge clk);
      chk("R3 done cleared", {31'b0, done}, 32'd0);
    end

    // hand-derived quotients
    run(1'b0, 32'd100, 32'd7, 1'b0, 1'b0);
    chk("R4 100/7", quo, 32'd14);
    run(1'b1, 32'h0003_0000, 32'h0002_0000, 1'b0, 1'b0);
    chk("R5 3.0/2.0", quo, 32'h0001_8000);

    // divide by zero
    run(1'b0, 32'h0000_ABCD, 32'd0, 1'b0, 1'b0);
    chk("R9 div0 quotient", quo, 32'hFFFF_FFFF);
    chk("R9 div0 remainder", rem, 32'h0000_ABCD);

    // inputs change during busy
    e = model(1'b0, 32'd1000, 32'd13);
    run(1'b0, 32'd1000, 32'd13, 1'b1, 1'b0);
    chk("R8 quotient unaffected", quo, e[63:32]);
    chk("R8 remainder unaffected", rem, e[31:0]);

    // start while busy
    e = model(1'b1, 32'h0005_0000, 32'h0000_0007);
    run(1'b1, 32'h0005_0000, 32'h0000_0007, 1'b0, 1'b1);
    chk("R7 quotient unaffected", quo, e[63:32]);
    chk("R7 remainder unaffected", rem, e[31:0]);

    // hold after done
    hq = quo; hr = rem;
    dvd = 32'hDEAD_BEEF; dvs = 32'd1; mode = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 quotient held", quo, hq);
    chk("R10 remainder held", rem, hr);
    chk("R3 done stays low", {31'b0, done}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule